// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Saturation

This block is the integer execution stage of a processor datapath. Each issued operation takes a first operand and a second operand. The first operand comes either from a register or from an instruction immediate. The second operand always comes from a register. The block returns a result, a write-enable for the destination register and an updated status word.

The status word holds five flags: zero, sign, carry, overflow and a sticky saturation flag. The block keeps this status word internally and presents it on an output port.

The operations are:
- add, subtract, reverse subtract and compare;
- saturating add and saturating subtract, which clamp to the most positive or most negative value on signed overflow;
- the bitwise operations AND, OR, XOR, NOT and a non-writing AND test.

Each operation is captured on one clock edge. Its result and flags appear together on the outputs after that edge.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low and after its release, `result`, `wr_en`, `done` and `flags` are all zero.
- R2: The first operand A is chosen by `src_sel`. A value of 0 or 3 selects `src_a`. A value of 1 selects the low SIW bits of `imm`, sign-extended. A value of 2 selects all LIW bits of `imm`; these are zero-extended for the bitwise codes 6 to 10 and sign-extended for every other code. The second operand B is always `src_b`.
- R3: Add (code 0) writes B+A modulo 2^DW. CY (`flags[2]`) is the unsigned carry out. OV (`flags[3]`) is set when A and B have the same sign and the result's sign differs from it. Z (`flags[0]`) is set when the result is zero. S (`flags[1]`) equals the result's top bit.
- R4: Subtract (code 1) writes B−A, with B as the minuend. Reverse subtract (code 2) writes A−B, with A as the minuend. CY is set when the minuend is less than the subtrahend as unsigned values. OV is set when the operand signs differ and the result's sign differs from the minuend's sign. Z and S follow the result as in R3.
- R5: Compare (code 3) updates Z, S, CY and OV exactly as subtract does. It leaves `wr_en` low and leaves `result` unchanged.
- R6: Saturating add (code 4) computes B+A and saturating subtract (code 5) computes B−A. On signed overflow, the written value is the most negative value if the reference operand is negative and the most positive value otherwise. The reference operand is A for the add and the minuend B for the subtract. Z, S, CY and OV come from the unclamped result.
- R7: SAT (`flags[4]`) is set by any saturating operation that overflows. Once set, only reset clears it.
- R8: AND (6), OR (7), XOR (8), NOT (9, which writes ~A) and test (10, which is A AND B with no write) set Z and S from their value and clear OV. They leave CY and SAT unchanged.
- R9: For an operation issued with `op_valid` high at one rising edge, `done`, `wr_en`, `result` and `flags` reflect it after that same edge. In a cycle with `op_valid` low, `done` and `wr_en` are low and `result` and `flags` hold.
- R10: Codes 11 to 15 pulse `done` but leave `wr_en` low, `result` unchanged and `flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issues the operation present on the inputs |
| op_code | input | 4 | Operation code, see R3 to R10 |
| src_sel | input | 2 | First-operand source select, see R2 |
| src_a | input | DW | First register operand |
| src_b | input | DW | Second register operand |
| imm | input | LIW | Immediate field |
| result | output | DW | Registered result |
| wr_en | output | 1 | Destination write enable for the registered result |
| done | output | 1 | One-cycle pulse per issued operation |
| flags | output | 5 | Status word {SAT, OV, CY, S, Z} |

## Verification
The bench exercises the following corner cases, each with the error it would expose:
- Operands straddling the signed limits (0x7F, 0x80, 0xFF in the 8-bit bench configuration). A design with the minuend swapped would produce wrong carry or overflow bits here.
- An overflow whose unclamped result wraps to zero. A design that takes Z from the clamped value instead of the raw one would fail on this case.
- Clamping direction for saturating subtract. A design that checks the subtrahend's sign instead of the minuend's would clamp to the wrong limit.
- A 6-bit immediate with its top bit set, used once with a bitwise code and once with an arithmetic code. This catches zero-extension and sign-extension being swapped.
- Bitwise operations run after a carry has been produced. A design that clears CY, or a saturation flag that decays, would fail here.
- Idle cycles and undefined codes interleaved with the sweep. These would reveal a stray write or flag change.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int DW  = 32,
  parameter int SIW = 5,
  parameter int LIW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [3:0]     op_code,
  input  logic [1:0]     src_sel,
  input  logic [DW-1:0]  src_a,
  input  logic [DW-1:0]  src_b,
  input  logic [LIW-1:0] imm,
  output logic [DW-1:0]  result,
  output logic           wr_en,
  output logic           done,
  output logic [4:0]     flags
);
  localparam int MSB = DW - 1;
  localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_RSB = 4'd2, OP_CMP = 4'd3,
                         OP_SADD = 4'd4, OP_SSUB = 4'd5, OP_AND = 4'd6, OP_OR = 4'd7,
                         OP_XOR = 4'd8, OP_NOT = 4'd9, OP_TST = 4'd10;

  logic          is_logic, is_arith, do_add, rev, sat_op, ref_neg;
  logic [DW-1:0] opa, min_v, sub_v, raw, arith_res, lg_res, nres;
  logic [DW:0]   sum, diff;
  logic          add_ov, sub_ov, ar_cy, ar_ov, nwr;
  logic [4:0]    nf;

  assign is_logic = (op_code >= OP_AND) && (op_code <= OP_TST);
  assign is_arith = (op_code <= OP_SSUB);
  assign do_add   = (op_code == OP_ADD) || (op_code == OP_SADD);
  assign rev      = (op_code == OP_RSB);
  assign sat_op   = (op_code == OP_SADD) || (op_code == OP_SSUB);

  always_comb begin
    case (src_sel)
      2'd1:    opa = {{(DW-SIW){imm[SIW-1]}}, imm[SIW-1:0]};
      2'd2:    opa = is_logic ? {{(DW-LIW){1'b0}}, imm} : {{(DW-LIW){imm[LIW-1]}}, imm};
      default: opa = src_a;
    endcase
  end

  assign min_v = rev ? opa : src_b;
  assign sub_v = rev ? src_b : opa;
  assign sum   = {1'b0, src_b} + {1'b0, opa};
  assign diff  = {1'b0, min_v} - {1'b0, sub_v};

  assign add_ov = (opa[MSB] == src_b[MSB]) && (sum[MSB] != opa[MSB]);
  assign sub_ov = (min_v[MSB] != sub_v[MSB]) && (diff[MSB] != min_v[MSB]);

  assign raw     = do_add ? sum[DW-1:0] : diff[DW-1:0];
  assign ar_cy   = do_add ? sum[DW] : diff[DW];
  assign ar_ov   = do_add ? add_ov : sub_ov;
  assign ref_neg = do_add ? opa[MSB] : min_v[MSB];
  assign arith_res = (sat_op && ar_ov) ? (ref_neg ? MINV : MAXV) : raw;

  always_comb begin
    case (op_code)
      OP_OR:   lg_res = opa | src_b;
      OP_XOR:  lg_res = opa ^ src_b;
      OP_NOT:  lg_res = ~opa;
      default: lg_res = opa & src_b;
    endcase
  end

  always_comb begin
    nres = result;
    nwr  = 1'b0;
    nf   = flags;
    if (is_arith) begin
      nres  = arith_res;
      nwr   = (op_code != OP_CMP);
      nf[0] = (raw == '0);
      nf[1] = raw[MSB];
      nf[2] = ar_cy;
      nf[3] = ar_ov;
      nf[4] = flags[4] | (sat_op & ar_ov);
    end else if (is_logic) begin
      nres  = lg_res;
      nwr   = (op_code != OP_TST);
      nf[0] = (lg_res == '0);
      nf[1] = lg_res[MSB];
      nf[3] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      wr_en  <= 1'b0;
      done   <= 1'b0;
      flags  <= '0;
    end else begin
      done  <= op_valid;
      wr_en <= op_valid && nwr;
      if (op_valid) begin
        if (nwr) result <= nres;
        flags <= nf;
      end
    end
  end

  AST_CMP_TST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op_code == OP_CMP || op_code == OP_TST) |=> !wr_en && $stable(result)); // R5
  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && sat_op && ar_ov |=> (result == MAXV || result == MINV) && flags[4]); // R6
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] |=> flags[4]); // R7
  AST_LOGIC_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_logic |=> !flags[3] && (flags[2] == $past(flags[2]))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !wr_en && !done && $stable(flags) && $stable(result)); // R9
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !flags[3] |-> flags[0] == (result == '0)); // R3
  AST_UNDEF_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code > OP_TST |=> done && !wr_en && $stable(flags)); // R10
endmodule

// File: tb/flag_alu_test.sv
`timescale 1ns/1ps
module flag_alu_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [1:0] src_sel = '0;
  logic [7:0] src_a = '0, src_b = '0;
  logic [5:0] imm = '0;
  logic [7:0] result;
  logic       wr_en, done;
  logic [4:0] flags;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_res = '0;
  logic [4:0] exp_f = '0;

  flag_alu #(.DW(8), .SIW(5), .LIW(6)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_sel(src_sel), .src_a(src_a), .src_b(src_b), .imm(imm),
    .result(result), .wr_en(wr_en), .done(done), .flags(flags));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic ew, input logic ed);
    checks++;
    if (result !== exp_res || wr_en !== ew || done !== ed || flags !== exp_f) begin
      errors++;
      $display("FAIL %s: res=%h wr=%b done=%b flags=%b expected res=%h wr=%b done=%b flags=%b",
               tag, result, wr_en, done, flags, exp_res, ew, ed, exp_f);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R3";
      4'd1, 4'd2: return "R4";
      4'd3: return "R5";
      4'd4, 4'd5: return "R6";
      4'd6, 4'd7, 4'd8, 4'd9, 4'd10: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [1:0] sel, input logic [7:0] a,
                       input logic [7:0] b, input logic [5:0] im, output logic wr);
    logic lg;
    logic [7:0] av, rr, wv;
    int ua, ub, sa, sb, r, sr;
    logic cy, ov;
    lg = (op >= 6 && op <= 10);
    case (sel)
      2'd1: av = {{3{im[4]}}, im[4:0]};
      2'd2: av = lg ? {2'b00, im} : {{2{im[5]}}, im};
      default: av = a;
    endcase
    ua = av; ub = b;
    sa = (ua > 127) ? ua - 256 : ua;
    sb = (ub > 127) ? ub - 256 : ub;
    wr = 1'b0;
    if (op <= 5) begin
      if (op == 0 || op == 4) begin r = ua + ub; sr = sa + sb; cy = (r > 255); end
      else if (op == 2) begin r = ua - ub; sr = sa - sb; cy = (ua < ub); end
      else begin r = ub - ua; sr = sb - sa; cy = (ub < ua); end
      ov = (sr > 127) || (sr < -128);
      rr = r[7:0];
      wv = rr;
      if (ov && op == 4) wv = (sa < 0) ? 8'h80 : 8'h7F;
      if (ov && op == 5) wv = (sb < 0) ? 8'h80 : 8'h7F;
      exp_f[0] = (rr == 0); exp_f[1] = rr[7]; exp_f[2] = cy; exp_f[3] = ov;
      if (ov && (op == 4 || op == 5)) exp_f[4] = 1'b1;
      wr = (op != 3);
    end else if (lg) begin
      case (op)
        4'd7: wv = av | b;
        4'd8: wv = av ^ b;
        4'd9: wv = ~av;
        default: wv = av & b;
      endcase
      exp_f[0] = (wv == 0); exp_f[1] = wv[7]; exp_f[3] = 1'b0;
      wr = (op != 10);
    end else wv = exp_res;
    if (wr) exp_res = wv;
  endtask

  task automatic run_op(input logic [3:0] op, input logic [1:0] sel, input logic [7:0] a,
                        input logic [7:0] b, input logic [5:0] im, input string tag);
    logic ew;
    op_code = op; src_sel = sel; src_a = a; src_b = b; imm = im; op_valid = 1'b1;
    model(op, sel, a, b, im, ew);
    @(negedge clk);
    op_valid = 1'b0;
    chk(tag, ew, 1'b1);
  endtask

  task automatic idle(input logic [7:0] junk);
    op_code = junk[3:0]; src_a = junk; src_b = ~junk; imm = junk[5:0]; op_valid = 1'b0;
    @(negedge clk);
    chk("R9", 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    exp_res = '0; exp_f = '0;
    chk("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] edges [6];
    edges = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF};
    @(negedge clk);
    do_reset();

    // R2: immediate selection and extension
    run_op(4'd0, 2'd1, 8'h00, 8'h05, 6'h1F, "R2");
    run_op(4'd6, 2'd2, 8'h00, 8'hFF, 6'h20, "R2");
    if (result !== 8'h20) begin errors++; $display("FAIL R2: res=%h expected 20", result); end
    checks++;
    run_op(4'd0, 2'd2, 8'hAA, 8'h00, 6'h20, "R2");
    if (result !== 8'hE0) begin errors++; $display("FAIL R2: res=%h expected e0", result); end
    checks++;
    run_op(4'd7, 2'd3, 8'h3C, 8'h00, 6'h3F, "R2");
    run_op(4'd1, 2'd1, 8'h00, 8'h10, 6'h10, "R2");

    // R7: sticky SAT
    do_reset();
    run_op(4'd4, 2'd0, 8'h01, 8'h7F, 6'h0, "R6");
    run_op(4'd0, 2'd0, 8'h01, 8'h01, 6'h0, "R7");
    run_op(4'd5, 2'd0, 8'h01, 8'h05, 6'h0, "R7");
    run_op(4'd6, 2'd0, 8'h00, 8'h00, 6'h0, "R7");
    checks++;
    if (flags[4] !== 1'b1) begin errors++; $display("FAIL R7: sat=%b expected 1", flags[4]); end
    run_op(4'd5, 2'd0, 8'h01, 8'h80, 6'h0, "R6");
    run_op(4'd4, 2'd0, 8'h80, 8'h80, 6'h0, "R6");

    // R8: CY preserved across logic ops
    do_reset();
    run_op(4'd0, 2'd0, 8'hFF, 8'h02, 6'h0, "R3");
    run_op(4'd8, 2'd0, 8'hFF, 8'hFF, 6'h0, "R8");
    run_op(4'd10, 2'd0, 8'h80, 8'h80, 6'h0, "R8");
    run_op(4'd3, 2'd0, 8'h05, 8'h05, 6'h0, "R5");
    run_op(4'd12, 2'd0, 8'h05, 8'h07, 6'h0, "R10");
    idle(8'h5A);

    // edge-value sweep
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          run_op(op[3:0], 2'd0, edges[i], edges[j], 6'h0, tag_of(op[3:0]));

    // stepped sweep over all codes and sources
    for (int op = 0; op < 16; op++)
      for (int sel = 0; sel < 3; sel++)
        for (int i = 0; i < 256; i += 13)
          for (int j = 0; j < 256; j += 11) begin
            run_op(op[3:0], sel[1:0], i[7:0], j[7:0], i[5:0] ^ j[5:0],
                   (sel != 0) ? "R2" : tag_of(op[3:0]));
            if (((i + j) % 8) == 0) idle(i[7:0] + j[7:0]);
          end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule